// File: doc/BRIEF.md
# Battery-Domain Seconds Clock with Alarm

This block is a memory-mapped real-time clock split across two clocks. A fast bus-side register port accepts reads and writes, while a slow always-on domain keeps a free-running sub-second tick counter, a 32-bit seconds count, a seconds alarm, a control word, sticky status flags and a glitch-pattern word. Every bus write is handed to the slow domain through a toggle handshake. It takes effect on the third slow edge after the write. Reads return a mirror of the slow registers that the bus side refreshes once per slow tick.

The block starts in an init state and steps to a non-valid state, then to a valid state. Each step needs a specific control setting, and the first step also needs the armed pattern word. Seconds only advance in the valid state with low-power enable set. Software must space its writes at least four slow periods apart and wait a few slow periods before reading back a result. The slow clock must be at least six bus clocks long.

Top module: `lp_rtc_block`

## Requirements
- R1: After reset, all readable registers return 0, and `alarm_irq` and `alarm_wake` are low.
- R2: The block leaves init, setting status bit 15, only when control bits 15 and 11 are 1 and the pattern register (offset 0x18) holds 0x41736166.
- R3: The block leaves non-valid, setting status bit 14, only after R2 has happened and while control bits 15, 14, 11 and 3 are all 1.
- R4: A write to the seconds register (offset 0x00) is accepted in any state, but the seconds value does not change by itself until the valid state is reached.
- R5: The sub-second counter (offset 0x04, SUB_W bits) advances on every slow tick in every state.
- R6: In the valid state with control bit 3 set, the seconds value rises by exactly 1 each time the sub-second counter wraps.
- R7: Writing to the status register (offset 0x14) clears each flag whose data bit is 1 and leaves the other flags alone. An all-ones write clears every flag.
- R8: In the valid state, status bit 3 (alarm pending) becomes 1 when the seconds value equals the alarm register (offset 0x08). It then stays 1 until it is cleared.
- R9: `alarm_irq` is high exactly when alarm pending and control bit 7 are both 1. `alarm_wake` is high exactly when alarm pending and control bit 4 are both 1.
- R10: A bus write takes effect in the slow domain on the third slow edge after the write, and never earlier.
- R11: The control register (offset 0x10) reads back bits 15, 14, 11, 7, 4 and 3 as written. All its other bits read 0.
- R12: A read of an unmapped offset (for example 0x0C or 0x1C) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus-side register clock |
| clk_slow | input | 1 | Always-on slow counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_sel | input | 1 | Access strobe, one bus cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| alarm_irq | output | 1 | Alarm interrupt |
| alarm_wake | output | 1 | Alarm wakeup request |

## Verification
The hardest state to reach is an alarm match in the valid state. Getting there needs the full ordered unlock: a failed attempt without the pattern, the init exit, a refused non-valid exit without low-power enable, and finally the accepted exit. The bench then reads the live seconds value and programs the alarm a few seconds ahead. It waits past the match before checking the sticky flag and both outputs. The bench overrides the sub-second width to 3 bits, so one second lasts only eight slow ticks and the wait stays short.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DW = 32;

  localparam logic [4:0] OFF_SEC = 5'h00;
  localparam logic [4:0] OFF_SUB = 5'h04;
  localparam logic [4:0] OFF_ALM = 5'h08;
  localparam logic [4:0] OFF_CTL = 5'h10;
  localparam logic [4:0] OFF_STS = 5'h14;
  localparam logic [4:0] OFF_GLT = 5'h18;

  localparam int B_LPEN  = 3;
  localparam int B_WAKE  = 4;
  localparam int B_AIE   = 7;
  localparam int B_NSA   = 11;
  localparam int B_NVREQ = 14;
  localparam int B_INREQ = 15;

  localparam int S_PEND  = 3;
  localparam int S_NVOUT = 14;
  localparam int S_INOUT = 15;

  localparam logic [DW-1:0] GLT_ARM = 32'h4173_6166;

  typedef enum logic [1:0] {
    ST_INIT     = 2'd0,
    ST_NONVALID = 2'd1,
    ST_VALID    = 2'd2
  } rtc_state_e;

  typedef struct packed {
    logic in_req;
    logic nv_req;
    logic nsa;
    logic aie;
    logic wake;
    logic lpen;
  } rtc_ctl_t;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= 2'b00;
    else         sr_q <= {sr_q[0], 1'b1};
  end

  assign srst_n = sr_q[1];
endmodule

// File: rtl/rtc_bus_side.sv
module rtc_bus_side
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SUB_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              cmd_tgl,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DW-1:0]     cmd_data,
  input  logic              hb_tgl,
  input  logic [DW-1:0]     s_sec,
  input  logic [SUB_W-1:0]  s_sub,
  input  logic [DW-1:0]     s_alm,
  input  logic [DW-1:0]     s_ctl,
  input  logic [DW-1:0]     s_sts,
  input  logic [DW-1:0]     s_glt
);
  localparam int NSYNC = 3;

  logic              wr_fire, rd_fire, cap;
  logic [NSYNC-1:0]  hb_q, hb_d;
  logic              tgl_d;
  logic [ADDR_W-1:0] caddr_d;
  logic [DW-1:0]     cdata_d;
  logic [DW-1:0]     m_sec, m_alm, m_ctl, m_sts, m_glt;
  logic [SUB_W-1:0]  m_sub;
  logic [DW-1:0]     rd_mux, rdata_d;

  assign wr_fire = sel & wr;
  assign rd_fire = sel & ~wr;

  // write command capture: one toggle per write
  always_comb begin
    tgl_d   = cmd_tgl;
    caddr_d = cmd_addr;
    cdata_d = cmd_data;
    if (wr_fire) begin
      tgl_d   = ~cmd_tgl;
      caddr_d = addr;
      cdata_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_tgl  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      cmd_tgl  <= tgl_d;
      cmd_addr <= caddr_d;
      cmd_data <= cdata_d;
    end
  end

  // heartbeat synchroniser; capture when the slow side has just ticked
  assign hb_d = {hb_q[NSYNC-2:0], hb_tgl};
  assign cap  = hb_q[NSYNC-1] ^ hb_q[NSYNC-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hb_q <= '0;
    else        hb_q <= hb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec <= '0;
      m_sub <= '0;
      m_alm <= '0;
      m_ctl <= '0;
      m_sts <= '0;
      m_glt <= '0;
    end else if (cap) begin
      m_sec <= s_sec;
      m_sub <= s_sub;
      m_alm <= s_alm;
      m_ctl <= s_ctl;
      m_sts <= s_sts;
      m_glt <= s_glt;
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    if (ADDR_W'(OFF_SEC) == addr) rd_mux = m_sec;
    if (ADDR_W'(OFF_SUB) == addr) rd_mux = DW'(m_sub);
    if (ADDR_W'(OFF_ALM) == addr) rd_mux = m_alm;
    if (ADDR_W'(OFF_CTL) == addr) rd_mux = m_ctl;
    if (ADDR_W'(OFF_STS) == addr) rd_mux = m_sts;
    if (ADDR_W'(OFF_GLT) == addr) rd_mux = m_glt;
    rdata_d = rd_fire ? rd_mux : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end
endmodule

// File: rtl/rtc_wr_sync.sv
module rtc_wr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic apply
);
  logic [STAGES:0] sq, sq_d;

  assign sq_d  = {sq[STAGES-1:0], tgl_in};
  assign apply = sq[STAGES] ^ sq[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= '0;
    else        sq <= sq_d;
  end
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SUB_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     sec,
  output logic [SUB_W-1:0]  sub,
  output logic [DW-1:0]     alm,
  output logic [DW-1:0]     glt,
  output logic [DW-1:0]     ctl_word,
  output logic [DW-1:0]     sts_word,
  output logic              hb_tgl,
  output rtc_state_e        state,
  output logic              pend,
  output logic              sec_wr,
  output logic              irq,
  output logic              wake
);
  rtc_ctl_t   ctl, ctl_d;
  rtc_state_e state_d;
  logic [DW-1:0]    sec_d, alm_d, glt_d;
  logic [SUB_W-1:0] sub_d;
  logic             pend_d, inout_q, inout_d, nvout_q, nvout_d;
  logic             hit_alm, hit_ctl, hit_sts, hit_glt;
  logic             wrap, cnt_en, match;

  assign sec_wr  = apply && (wr_addr == ADDR_W'(OFF_SEC));
  assign hit_alm = apply && (wr_addr == ADDR_W'(OFF_ALM));
  assign hit_ctl = apply && (wr_addr == ADDR_W'(OFF_CTL));
  assign hit_sts = apply && (wr_addr == ADDR_W'(OFF_STS));
  assign hit_glt = apply && (wr_addr == ADDR_W'(OFF_GLT));

  assign wrap   = &sub;
  assign cnt_en = (state == ST_VALID) && ctl.lpen;
  assign match  = (state == ST_VALID) && (sec == alm);

  always_comb begin
    sub_d = sub + 1'b1;
    sec_d = sec;
    if (sec_wr)             sec_d = wr_data;
    else if (cnt_en && wrap) sec_d = sec + 1'b1;
    alm_d = hit_alm ? wr_data : alm;
    glt_d = hit_glt ? wr_data : glt;
    ctl_d = ctl;
    if (hit_ctl) begin
      ctl_d.in_req = wr_data[B_INREQ];
      ctl_d.nv_req = wr_data[B_NVREQ];
      ctl_d.nsa    = wr_data[B_NSA];
      ctl_d.aie    = wr_data[B_AIE];
      ctl_d.wake   = wr_data[B_WAKE];
      ctl_d.lpen   = wr_data[B_LPEN];
    end
  end

  // state sequence and sticky flags (a new event wins over a clear)
  always_comb begin
    state_d = state;
    inout_d = inout_q & ~(hit_sts & wr_data[S_INOUT]);
    nvout_d = nvout_q & ~(hit_sts & wr_data[S_NVOUT]);
    pend_d  = (pend & ~(hit_sts & wr_data[S_PEND])) | match;
    case (state)
      ST_INIT: begin
        if (ctl.in_req && ctl.nsa && (glt == GLT_ARM)) begin
          state_d = ST_NONVALID;
          inout_d = 1'b1;
        end
      end
      ST_NONVALID: begin
        if (ctl.in_req && ctl.nv_req && ctl.nsa && ctl.lpen) begin
          state_d = ST_VALID;
          nvout_d = 1'b1;
        end
      end
      ST_VALID: state_d = ST_VALID;
      default:  state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub     <= '0;
      sec     <= '0;
      alm     <= '0;
      glt     <= '0;
      ctl     <= '0;
      state   <= ST_INIT;
      inout_q <= 1'b0;
      nvout_q <= 1'b0;
      pend    <= 1'b0;
      hb_tgl  <= 1'b0;
    end else begin
      sub     <= sub_d;
      sec     <= sec_d;
      alm     <= alm_d;
      glt     <= glt_d;
      ctl     <= ctl_d;
      state   <= state_d;
      inout_q <= inout_d;
      nvout_q <= nvout_d;
      pend    <= pend_d;
      hb_tgl  <= ~hb_tgl;
    end
  end

  always_comb begin
    ctl_word          = '0;
    ctl_word[B_INREQ] = ctl.in_req;
    ctl_word[B_NVREQ] = ctl.nv_req;
    ctl_word[B_NSA]   = ctl.nsa;
    ctl_word[B_AIE]   = ctl.aie;
    ctl_word[B_WAKE]  = ctl.wake;
    ctl_word[B_LPEN]  = ctl.lpen;
    sts_word          = '0;
    sts_word[S_INOUT] = inout_q;
    sts_word[S_NVOUT] = nvout_q;
    sts_word[S_PEND]  = pend;
  end

  assign irq  = pend & ctl.aie;
  assign wake = pend & ctl.wake;
endmodule

// File: rtl/lp_rtc_block.sv
module lp_rtc_block
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SUB_W  = 15
) (
  input  logic              clk_bus,
  input  logic              clk_slow,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              alarm_irq,
  output logic              alarm_wake
);
  logic              brst_n, srst_n;
  logic              cmd_tgl, apply, hb_tgl;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DW-1:0]     cmd_data;
  logic [DW-1:0]     s_sec, s_alm, s_glt, s_ctl, s_sts;
  logic [SUB_W-1:0]  s_sub;
  rtc_state_e        core_state;
  logic              core_pend, core_sec_wr;

  rtc_rst_sync u_brst (.clk(clk_bus),  .arst_n(rst_n), .srst_n(brst_n));
  rtc_rst_sync u_srst (.clk(clk_slow), .arst_n(rst_n), .srst_n(srst_n));

  rtc_bus_side #(.ADDR_W(ADDR_W), .SUB_W(SUB_W)) u_bus (
    .clk(clk_bus), .rst_n(brst_n),
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata),
    .cmd_tgl(cmd_tgl), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .hb_tgl(hb_tgl),
    .s_sec(s_sec), .s_sub(s_sub), .s_alm(s_alm),
    .s_ctl(s_ctl), .s_sts(s_sts), .s_glt(s_glt)
  );

  rtc_wr_sync #(.STAGES(2)) u_wsync (
    .clk(clk_slow), .rst_n(srst_n), .tgl_in(cmd_tgl), .apply(apply)
  );

  rtc_slow_core #(.ADDR_W(ADDR_W), .SUB_W(SUB_W)) u_core (
    .clk(clk_slow), .rst_n(srst_n),
    .apply(apply), .wr_addr(cmd_addr), .wr_data(cmd_data),
    .sec(s_sec), .sub(s_sub), .alm(s_alm), .glt(s_glt),
    .ctl_word(s_ctl), .sts_word(s_sts), .hb_tgl(hb_tgl),
    .state(core_state), .pend(core_pend), .sec_wr(core_sec_wr),
    .irq(alarm_irq), .wake(alarm_wake)
  );
endmodule

// File: rtl/rtc_sva.sv
module rtc_sva
  import rtc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          tgl,
  input logic          apply,
  input rtc_state_e    state,
  input logic [DW-1:0] sec,
  input logic [DW-1:0] alm,
  input logic [DW-1:0] glt,
  input logic          pend,
  input logic          sec_wr
);
  // R2: init exit only with the armed pattern
  a_r2_pattern_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NONVALID && $past(state) == ST_INIT) |-> $past(glt) == GLT_ARM);

  // R3: valid is only entered from non-valid
  a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VALID && $past(state) != ST_VALID) |-> $past(state) == ST_NONVALID);

  // R4: seconds frozen outside the valid state unless written
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_VALID && !sec_wr) |=> $stable(sec));

  // R6: self-driven seconds change is a step of one
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sec != $past(sec) && !$past(sec_wr)) |-> sec == $past(sec) + 32'd1);

  // R8: a match in the valid state raises pending
  a_r8_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VALID && sec == alm) |=> pend);

  // R10: a write is never applied on the edge right after the toggle moves
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl != $past(tgl)) |-> !apply);
endmodule

bind lp_rtc_block rtc_sva u_rtc_sva (
  .clk(clk_slow), .rst_n(srst_n), .tgl(cmd_tgl), .apply(apply),
  .state(core_state), .sec(s_sec), .alm(s_alm), .glt(s_glt),
  .pend(core_pend), .sec_wr(core_sec_wr)
);

// File: tb/lp_rtc_block_bench.sv
module lp_rtc_block_bench;
  localparam int AW = 5;
  localparam logic [31:0] MAGIC = 32'h4173_6166;

  logic clk_bus = 1'b0, clk_slow = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic alarm_irq, alarm_wake;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sbq[$];
  logic use_sb = 1'b0, rd_fire = 1'b0;

  always #5 clk_bus = ~clk_bus;
  initial begin #3; forever #50 clk_slow = ~clk_slow; end

  lp_rtc_block #(.ADDR_W(AW), .SUB_W(3)) u_lp_rtc_block (
    .clk_bus(clk_bus), .clk_slow(clk_slow), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq), .alarm_wake(alarm_wake)
  );

  // monitor: pops the expected value for each scoreboarded read
  always @(posedge clk_bus) rd_fire <= bus_sel & ~bus_wr & use_sb;
  always @(negedge clk_bus) begin
    if (rd_fire) begin
      exp_t e;
      checks++;
      if (sbq.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
      end else begin
        e = sbq.pop_front();
        if (bus_rdata !== e.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_true(input string tag, input bit ok, input logic [31:0] act,
                            input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_sel = 1'b0; bus_wr = 1'b0;
    repeat (90) @(negedge clk_bus);
  endtask

  task automatic expect_read(input logic [AW-1:0] a, input logic [31:0] exp,
                             input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk_bus);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; use_sb = 1'b1;
    @(negedge clk_bus);
    bus_sel = 1'b0; use_sb = 1'b0;
    @(negedge clk_bus);
  endtask

  task automatic raw_read(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk_bus);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk_bus);
    bus_sel = 1'b0;
    v = bus_rdata;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a, b, s;
    repeat (5) @(negedge clk_bus);
    rst_n = 1'b1;
    repeat (60) @(negedge clk_bus);

    // R1 reset state
    expect_read(5'h00, 32'h0, "R1 seconds");
    expect_read(5'h08, 32'h0, "R1 alarm");
    expect_read(5'h10, 32'h0, "R1 control");
    expect_read(5'h14, 32'h0, "R1 status");
    expect_read(5'h18, 32'h0, "R1 pattern");
    check_bit("R1 irq", alarm_irq, 1'b0);
    check_bit("R1 wake", alarm_wake, 1'b0);

    // R12 unmapped offsets
    expect_read(5'h0C, 32'h0, "R12 offset 0x0C");
    expect_read(5'h1C, 32'h0, "R12 offset 0x1C");

    // R5 heartbeat runs before the block is valid
    raw_read(5'h04, a);
    repeat (30) @(negedge clk_bus);
    raw_read(5'h04, b);
    check_true("R5 sub-second advances", a != b, b, a + 32'd3);

    // R4 write accepted but frozen; R10 write reaches slow domain
    bus_write(5'h00, 32'd5);
    expect_read(5'h00, 32'd5, "R4 R10 seconds written");
    bus_write(5'h10, 32'h0000_C808);
    expect_read(5'h10, 32'h0000_C808, "R11 control readback");
    expect_read(5'h14, 32'h0, "R2 R3 no exit without pattern");
    repeat (300) @(negedge clk_bus);
    expect_read(5'h00, 32'd5, "R4 frozen in init");

    // R11 undefined bits read zero
    bus_write(5'h10, 32'hFFFF_FFFF);
    expect_read(5'h10, 32'h0000_C898, "R11 only defined bits");

    // R2 wrong pattern then armed pattern
    bus_write(5'h10, 32'h0000_8800);
    bus_write(5'h18, 32'h1234_5678);
    expect_read(5'h14, 32'h0, "R2 wrong pattern");
    bus_write(5'h18, MAGIC);
    expect_read(5'h18, MAGIC, "R2 pattern readback");
    expect_read(5'h14, 32'h0000_8000, "R2 init exited");
    expect_read(5'h00, 32'd5, "R4 frozen in non-valid");

    // R3 needs low-power enable, then exits
    bus_write(5'h10, 32'h0000_C800);
    expect_read(5'h14, 32'h0000_8000, "R3 no exit without bit 3");
    bus_write(5'h10, 32'h0000_C808);
    expect_read(5'h14, 32'h0000_C000, "R3 non-valid exited");

    // R6 counting
    raw_read(5'h00, a);
    repeat (400) @(negedge clk_bus);
    raw_read(5'h00, b);
    check_true("R6 about five seconds", (b - a >= 4) && (b - a <= 6), b - a, 32'd5);

    // R7 write-one-to-clear
    bus_write(5'h14, 32'h0000_4000);
    expect_read(5'h14, 32'h0000_8000, "R7 single flag cleared");
    bus_write(5'h14, 32'hFFFF_FFFF);
    expect_read(5'h14, 32'h0, "R7 all flags cleared");

    // R8 R9 alarm
    bus_write(5'h10, 32'h0000_C898);
    raw_read(5'h00, s);
    bus_write(5'h08, s + 32'd5);
    expect_read(5'h08, s + 32'd5, "R8 alarm readback");
    expect_read(5'h14, 32'h0, "R8 not yet pending");
    check_bit("R9 irq before match", alarm_irq, 1'b0);
    repeat (800) @(negedge clk_bus);
    expect_read(5'h14, 32'h0000_0008, "R8 pending after match");
    check_bit("R9 irq after match", alarm_irq, 1'b1);
    check_bit("R9 wake after match", alarm_wake, 1'b1);

    bus_write(5'h10, 32'h0000_C818);
    check_bit("R9 irq masked", alarm_irq, 1'b0);
    check_bit("R9 wake still on", alarm_wake, 1'b1);

    bus_write(5'h14, 32'h0000_0008);
    expect_read(5'h14, 32'h0, "R7 R8 pending cleared");
    check_bit("R9 wake after clear", alarm_wake, 1'b0);

    repeat (5) @(negedge clk_bus);
    finish_run();
  end
endmodule